// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a recovered bipolar bit stream, one bit per clock cycle in which the bit-clock enable is high. It decides when the line has gone dead and when it has come back. Amplitude levels are not part of it; it applies only two digital rules. A long unbroken run of zero bits declares signal loss. Recovery needs a minimum mark density over a sliding window of bits, and the zero runs inside that window must stay bounded.

While loss is flagged, the block forces its two rail outputs low, so downstream framing logic sees no marks. Otherwise the rail inputs pass straight through. A bit counts as a mark when either rail input is high in its bit period.

Top module: `los_line_monitor`

## Requirements
- R1: During and right after reset, los_o is 1 and both rail outputs are 0, whatever the rail inputs are.
- R2: A bit is a mark when pos_in or neg_in is high on a clock edge where bit_en is 1. Marks on either rail count the same. Rail inputs on edges with bit_en low have no effect on any later result.
- R3: While los_o is 0, a run of DECLARE_ZEROS (default 175) consecutive zero bits sets los_o. It is visible right after the edge that samples the last zero of the run. A run one bit shorter that ends in a mark leaves los_o at 0.
- R4: While los_o is 1, the bits are collected into a window that starts empty when loss is declared. los_o clears right after the edge that samples a bit where the window holds WIN_LEN (default 175) bits and has at least ceil(WIN_LEN/8) marks (22 by default). With WIN_LEN-1 bits collected, los_o stays 1.
- R5: While los_o is 1, a full window with fewer than ceil(WIN_LEN/8) marks keeps los_o at 1. This includes 20 marks in 175 bits.
- R6: While los_o is 1, a zero bit that makes the current zero run longer than ZERO_RUN_MAX (default 100) empties the window, and collection restarts with the next bit. A run of exactly ZERO_RUN_MAX zeros does not restart it.
- R7: When los_o is 0, pos_o equals pos_in and neg_o equals neg_in in the same cycle. When los_o is 1, both are 0.
- R8: los_o changes only on clock edges where bit_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Bit-clock enable, one bit per high cycle |
| pos_in | input | 1 | Positive-rail mark of the current bit |
| neg_in | input | 1 | Negative-rail mark of the current bit |
| los_o | output | 1 | Registered loss-of-signal flag |
| pos_o | output | 1 | Positive rail, gated low during loss |
| neg_o | output | 1 | Negative rail, gated low during loss |

## Verification
Every decision is taken on the clock edge that samples the deciding bit, and los_o shows it one register later. The rail outputs follow los_o and the rail inputs in the same cycle, with no extra register. The bench puts each bit on the inputs at a falling edge, keeps bit_en high across exactly one rising edge, and reads the outputs at the next falling edge. Each check therefore sees the result of the bit just sent. Tests that must not clear too early stop one bit short of the full window, read los_o, and then send the final bit.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic {
    LINE_UP   = 1'b0,
    LINE_LOST = 1'b1
  } line_state_e;

  // marks needed for a one-in-eight density over a window, rounded up
  function automatic int unsigned min_marks(input int unsigned win);
    return (win + 7) / 8;
  endfunction

endpackage

// File: rtl/los_zero_run.sv
// Saturating counter of consecutive zero bits.
module los_zero_run #(
  parameter int unsigned SAT = 176,
  parameter int unsigned RW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          mark,
  output logic [RW-1:0] run_q,
  output logic [RW-1:0] run_next
);

  always_comb begin
    if (mark)
      run_next = '0;
    else if (run_q == RW'(SAT))
      run_next = run_q;
    else
      run_next = run_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (bit_en)
      run_q <= run_next;
  end

endmodule

// File: rtl/los_density_win.sv
// Sliding window of the last WIN_LEN bits with a running mark count
// and a fill level; clear empties it on an enabled bit.
module los_density_win #(
  parameter int unsigned WIN_LEN = 175,
  parameter int unsigned CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          mark,
  input  logic          clear,
  output logic [CW-1:0] marks_q,
  output logic [CW-1:0] marks_next,
  output logic          full_next
);

  logic [WIN_LEN-1:0] hist_q, hist_d;
  logic [CW-1:0]      fill_q, fill_d;
  logic [CW-1:0]      marks_d;

  always_comb begin
    hist_d  = {hist_q[WIN_LEN-2:0], mark};
    marks_d = marks_q + CW'(mark) - CW'(hist_q[WIN_LEN-1]);
    fill_d  = (fill_q == CW'(WIN_LEN)) ? fill_q : fill_q + CW'(1);
    if (clear) begin
      hist_d  = '0;
      marks_d = '0;
      fill_d  = '0;
    end
  end

  assign marks_next = marks_d;
  assign full_next  = (fill_d == CW'(WIN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      marks_q <= '0;
      fill_q  <= '0;
    end else if (bit_en) begin
      hist_q  <= hist_d;
      marks_q <= marks_d;
      fill_q  <= fill_d;
    end
  end

endmodule

// File: rtl/los_line_monitor.sv
module los_line_monitor
  import los_pkg::*;
#(
  parameter int unsigned DECLARE_ZEROS = 175,
  parameter int unsigned WIN_LEN       = 175,
  parameter int unsigned ZERO_RUN_MAX  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic pos_in,
  input  logic neg_in,
  output logic los_o,
  output logic pos_o,
  output logic neg_o
);

  localparam int unsigned RUN_SAT   = (DECLARE_ZEROS > ZERO_RUN_MAX) ? DECLARE_ZEROS
                                                                     : ZERO_RUN_MAX + 1;
  localparam int unsigned RW        = $clog2(RUN_SAT + 1);
  localparam int unsigned CW        = $clog2(WIN_LEN + 1);
  localparam int unsigned MIN_MARKS = min_marks(WIN_LEN);

  line_state_e   st_q, st_d;
  logic          mark;
  logic [RW-1:0] run_cnt, run_next;
  logic [CW-1:0] marks_cnt, marks_next;
  logic          full_next;
  logic          run_over;
  logic          win_clr;
  logic          density_ok;

  assign mark = pos_in | neg_in;

  los_zero_run #(
    .SAT (RUN_SAT),
    .RW  (RW)
  ) zrun_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .mark     (mark),
    .run_q    (run_cnt),
    .run_next (run_next)
  );

  assign run_over = (run_next > RW'(ZERO_RUN_MAX));
  // window only collects while the line is lost
  assign win_clr  = (st_q == LINE_UP) || run_over;

  los_density_win #(
    .WIN_LEN (WIN_LEN),
    .CW      (CW)
  ) win_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .mark       (mark),
    .clear      (win_clr),
    .marks_q    (marks_cnt),
    .marks_next (marks_next),
    .full_next  (full_next)
  );

  assign density_ok = full_next && (marks_next >= CW'(MIN_MARKS)) && !run_over;

  always_comb begin
    st_d = st_q;
    if (bit_en) begin
      case (st_q)
        LINE_UP:   if (run_next >= RW'(DECLARE_ZEROS)) st_d = LINE_LOST;
        LINE_LOST: if (density_ok) st_d = LINE_UP;
        default:   st_d = LINE_LOST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= LINE_LOST;
    else
      st_q <= st_d;
  end

  assign los_o = (st_q == LINE_LOST);

  logic [1:0] rail_in, rail_out;
  assign rail_in = {neg_in, pos_in};

  for (genvar g = 0; g < 2; g++) begin : g_rail
    assign rail_out[g] = rail_in[g] & ~los_o;
  end

  assign pos_o = rail_out[0];
  assign neg_o = rail_out[1];

endmodule

// File: rtl/los_line_monitor_chk.sv
module los_line_monitor_chk #(
  parameter int unsigned WIN_LEN = 175,
  parameter int unsigned RW      = 8,
  parameter int unsigned CW      = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          pos_in,
  input logic          neg_in,
  input logic          los_o,
  input logic          pos_o,
  input logic          neg_o,
  input logic [RW-1:0] run_cnt,
  input logic [CW-1:0] marks_cnt
);

  // R7: rails are held low during loss
  p_rails_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    los_o |-> (!pos_o && !neg_o));

  // R8: flag is frozen when no bit arrives
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(los_o));

  // R3: loss is only declared on a zero bit
  p_declare_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_o) |-> $past(bit_en && !(pos_in || neg_in)));

  // R2: a mark on either rail ends the zero run
  p_mark_resets_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (pos_in || neg_in)) |=> (run_cnt == '0));

  // R4: recovery needs enough marks in the window
  p_clear_density_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_o) |-> ((int'($past(marks_cnt)) + 1) * 8 >= int'(WIN_LEN)));

endmodule

bind los_line_monitor los_line_monitor_chk #(
  .WIN_LEN (WIN_LEN),
  .RW      (RW),
  .CW      (CW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .pos_in    (pos_in),
  .neg_in    (neg_in),
  .los_o     (los_o),
  .pos_o     (pos_o),
  .neg_o     (neg_o),
  .run_cnt   (run_cnt),
  .marks_cnt (marks_cnt)
);

// File: tb/los_line_monitor_tb_top.sv
module los_line_monitor_tb_top;

  logic clk;
  logic rst_n;
  logic bit_en;
  logic pos_in;
  logic neg_in;
  logic los_o;
  logic pos_o;
  logic neg_o;

  int checks = 0;
  int errors = 0;
  logic pol = 1'b0;

  los_line_monitor dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .pos_in (pos_in),
    .neg_in (neg_in),
    .los_o  (los_o),
    .pos_o  (pos_o),
    .neg_o  (neg_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [15:0] nbits;
    logic [7:0]  period;   // 0: all zeros; k: mark on every k-th bit starting at bit 0
    logic        exp_los;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd175, 8'd8, 1'b0, 4'd4},  // R4: 22 marks in a full window clears
    '{16'd1,   8'd1, 1'b0, 4'd3},  // R3: one mark
    '{16'd174, 8'd0, 1'b0, 4'd3},  // R3: 174 zeros do not declare
    '{16'd1,   8'd0, 1'b1, 4'd3},  // R3: 175th zero declares
    '{16'd175, 8'd9, 1'b1, 4'd5},  // R5: 20 marks is too few
    '{16'd101, 8'd0, 1'b1, 4'd6},  // R6: long run restarts collection
    '{16'd174, 8'd8, 1'b1, 4'd4},  // R4: one bit short of full window
    '{16'd1,   8'd0, 1'b0, 4'd4}   // R4: full window now clears
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic p, input logic n);
    @(negedge clk);
    pos_in = p;
    neg_in = n;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    pos_in = 1'b0;
    neg_in = 1'b0;
  endtask

  task automatic run_bits(input int nbits, input int period);
    for (int i = 0; i < nbits; i++) begin
      if (period != 0 && (i % period) == 0) begin
        send_bit(pol, !pol);
        pol = !pol;
      end else begin
        send_bit(1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    bit_en = 1'b0;
    pos_in = 1'b1;
    neg_in = 1'b1;
    repeat (3) @(negedge clk);
    check(los_o, 1'b1, "R1 los in reset");
    check(pos_o | neg_o, 1'b0, "R1 rails in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(los_o, 1'b1, "R1 los after reset");
    pos_in = 1'b0;
    neg_in = 1'b0;

    for (int v = 0; v < NV; v++) begin
      run_bits(int'(VECS[v].nbits), int'(VECS[v].period));
      check(los_o, VECS[v].exp_los, $sformatf("R%0d vector %0d", VECS[v].req, v));
    end

    // R7: pass-through while line is up
    @(negedge clk);
    pos_in = 1'b1;
    #1 check(pos_o, 1'b1, "R7 pos pass");
    check(neg_o, 1'b0, "R7 neg idle");
    neg_in = 1'b1;
    pos_in = 1'b0;
    #1 check(neg_o, 1'b1, "R7 neg pass");
    neg_in = 1'b0;

    // R3: declare again
    run_bits(175, 0);
    check(los_o, 1'b1, "R3 declare");

    // R7/R8/R2: marks without bit_en are ignored and rails stay low
    @(negedge clk);
    pos_in = 1'b1;
    neg_in = 1'b1;
    #1 check(pos_o | neg_o, 1'b0, "R7 rails low in loss");
    repeat (300) @(negedge clk);
    check(los_o, 1'b1, "R8 idle marks no effect");
    pos_in = 1'b0;
    neg_in = 1'b0;
    run_bits(174, 8);
    check(los_o, 1'b1, "R2 idle marks not counted");
    run_bits(1, 0);
    check(los_o, 1'b0, "R4 clear after idle");

    // R6: run of 111 zeros inside the window restarts
    run_bits(175, 0);
    check(los_o, 1'b1, "R3 declare before R6");
    run_bits(64, 3);
    run_bits(111, 0);
    check(los_o, 1'b1, "R6 long run blocks clear");
    // R6 boundary: run of exactly 100 zeros is tolerated
    run_bits(64, 3);
    run_bits(100, 0);
    run_bits(1, 1);
    run_bits(9, 0);
    check(los_o, 1'b1, "R6 window not yet full");
    run_bits(1, 0);
    check(los_o, 1'b0, "R6 run of 100 tolerated");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule